// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit connects a 32-bit register datapath to a byte-addressed data memory that has a 32-bit word port. Each request gives an operation code, a base register value, a 16-bit signed byte offset and, for stores, the source register value. The unit adds the sign-extended offset to the base to form the byte address. It passes the word part of that address to memory and uses the two low bits to pick a byte lane.

For stores, the unit drives per-byte write enables. A byte store repeats its source byte on every lane and enables only the addressed lane. For loads, it picks the addressed lane from the returned word. It then sign-extends or zero-extends that byte, or passes the full word through, and registers the result with a one-cycle valid strobe.

A word access whose byte address is not a multiple of four raises a fault flag at once. A faulting access does no memory write, issues no memory read and produces no write-back strobe.

Top module: `lsu_align_unit`

## Requirements
- R1: The byte address is `base` plus `offset` sign-extended to 32 bits, wrapping modulo 2^32. `mem_addr` carries that address shifted right by two bits, so consecutive words differ by 4 in byte address and by 1 on `mem_addr`.
- R2: An aligned word load (`req_op` = 1) asserts `mem_re` in the request cycle. Memory returns data one cycle later. `ld_valid` is high for exactly one cycle, two cycles after the request, with `ld_result` equal to the whole 32-bit memory word.
- R3: A word load or word store whose byte address has nonzero bits 1:0 asserts `align_fault` in the request cycle. In that cycle `mem_we` stays 0 and `mem_re` stays low, no `ld_valid` follows, and memory is unchanged.
- R4: A signed byte load (`req_op` = 2) returns the addressed byte in bits 7:0, with bits 31:8 copied from that byte's bit 7.
- R5: An unsigned byte load (`req_op` = 3) returns the addressed byte in bits 7:0, with bits 31:8 cleared.
- R6: Byte lanes are little-endian. Byte-address bits 1:0 equal to k select memory data bits 8k+7:8k and write-enable bit k, for both loads and stores.
- R7: A byte store (`req_op` = 5) puts `st_data[7:0]` on all four lanes of `mem_wdata` and asserts exactly one bit of `mem_we`, the addressed lane. It never faults.
- R8: An aligned word store (`req_op` = 4) drives `mem_wdata` = `st_data` and `mem_we` = 4'b1111.
- R9: After reset, and whenever `req_valid` is low or `req_op` is 0, 6 or 7 (no operation), `mem_we` is 0 and `mem_re`, `align_fault` and `ld_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | 0 none, 1 word load, 2 signed byte load, 3 unsigned byte load, 4 word store, 5 byte store |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed byte offset |
| st_data | input | 32 | Store source register value |
| mem_addr | output | 30 | Memory word address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 4 | Per-byte write enables, bit k for bits 8k+7:8k |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_re` |
| ld_result | output | 32 | Formatted load result |
| ld_valid | output | 1 | Load result valid, also the register write-back enable |
| align_fault | output | 1 | Misaligned word access |

## Verification
Every byte load runs on one word whose four lanes hold 0x01, 0x7F, 0xFF and 0x80. Each lane is a different byte, so a wrong lane is caught. The two high lanes have bit 7 set, so a wrong sign or zero fill is caught.

Addresses are formed from a positive offset, a negative offset and a base near the top of the address space. These tell a correct sign extension and wrap apart from zero extension or a byte-versus-word address slip.

Stores are read back through word loads. This shows that a byte store touched only its lane and that a misaligned store left memory alone. Misaligned, no-operation and unused op codes are checked directly at the memory strobes.

// File: rtl/lsu_pkg.sv
// Package: shared widths and encodings for the load/store alignment unit.
// Assumes a 32-bit datapath split into 8-bit lanes.
package lsu_pkg;
    localparam int XLEN   = 32;
    localparam int OFFW   = 16;
    localparam int LANES  = XLEN / 8;
    localparam int LANE_W = $clog2(LANES);

    // Request operation codes as seen on req_op.
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_LDW  = 3'd1,
        OP_LDB  = 3'd2,
        OP_LDBU = 3'd3,
        OP_STW  = 3'd4,
        OP_STB  = 3'd5
    } lsu_op_e;

    // Format applied to returned load data.
    typedef enum logic [1:0] {
        LK_WORD  = 2'd0,
        LK_SBYTE = 2'd1,
        LK_UBYTE = 2'd2
    } ld_kind_e;
endpackage

// File: rtl/lsu_addr_gen.sv
// Address generator: adds the sign-extended offset to the base.
// Splits the sum into a word address and a byte lane, and flags
// word accesses whose lane bits are nonzero. Purely combinational.
module lsu_addr_gen #(
    parameter int XLEN   = lsu_pkg::XLEN,
    parameter int OFFW   = lsu_pkg::OFFW,
    parameter int LANE_W = $clog2(XLEN / 8)
) (
    input  logic [XLEN-1:0]        base,
    input  logic [OFFW-1:0]        offset,
    input  logic                   word_acc,
    output logic [XLEN-LANE_W-1:0] word_addr,
    output logic [LANE_W-1:0]      lane,
    output logic                   misalign
);
    logic [XLEN-1:0] off_ext;
    logic [XLEN-1:0] byte_addr;

    // Sign-extend the offset and form the byte address.
    always_comb begin
        off_ext   = {{(XLEN-OFFW){offset[OFFW-1]}}, offset};
        byte_addr = base + off_ext;
    end

    // Split the address and test word alignment.
    always_comb begin
        word_addr = byte_addr[XLEN-1:LANE_W];
        lane      = byte_addr[LANE_W-1:0];
        misalign  = word_acc && (lane != '0);
    end
endmodule

// File: rtl/lsu_store_lanes.sv
// Store lane steering: a word store passes every lane straight through,
// a byte store repeats the low source byte on all lanes. Write enables
// follow the lane selection. Assumes the caller clears wr_en on faults.
module lsu_store_lanes #(
    parameter int XLEN   = lsu_pkg::XLEN,
    parameter int LANES  = XLEN / 8,
    parameter int LANE_W = $clog2(XLEN / 8)
) (
    input  logic              wr_en,
    input  logic              byte_mode,
    input  logic [LANE_W-1:0] lane,
    input  logic [XLEN-1:0]   src,
    output logic [LANES-1:0]  we,
    output logic [XLEN-1:0]   wdata
);
    // One steering slice per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wdata[8*g +: 8] = byte_mode ? src[7:0] : src[8*g +: 8];
        assign we[g]           = wr_en && (!byte_mode || (lane == LANE_W'(g)));
    end
endmodule

// File: rtl/lsu_load_extend.sv
// Load formatter: remembers the format and lane of an issued read and
// picks the lane from the word memory returns one cycle later. It then
// extends the byte and registers the result with a one-cycle strobe.
// Assumes memory read latency of exactly one cycle.
module lsu_load_extend
    import lsu_pkg::*;
#(
    parameter int XLEN   = lsu_pkg::XLEN,
    parameter int LANES  = XLEN / 8,
    parameter int LANE_W = $clog2(XLEN / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  ld_kind_e          kind,
    input  logic [LANE_W-1:0] lane,
    input  logic [XLEN-1:0]   rdata,
    output logic [XLEN-1:0]   result,
    output logic              valid
);
    logic              pend;
    ld_kind_e          kind_q;
    logic [LANE_W-1:0] lane_q;
    logic [7:0]        lane_bytes [LANES];
    logic [7:0]        picked;
    logic [XLEN-1:0]   fmt;

    // Stage 1: hold request attributes while memory reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            kind_q <= LK_WORD;
            lane_q <= '0;
        end else begin
            pend <= issue;
            if (issue) begin
                kind_q <= kind;
                lane_q <= lane;
            end
        end
    end

    // Unpack the returned word into lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign lane_bytes[g] = rdata[8*g +: 8];
    end

    // Pick the lane and apply the extension.
    always_comb begin
        picked = lane_bytes[lane_q];
        case (kind_q)
            LK_WORD:  fmt = rdata;
            LK_SBYTE: fmt = {{(XLEN-8){picked[7]}}, picked};
            default:  fmt = {{(XLEN-8){1'b0}}, picked};
        endcase
    end

    // Stage 2: register the formatted result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            result <= '0;
        end else begin
            valid <= pend;
            if (pend) result <= fmt;
        end
    end

    assert_valid_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(pend));
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !$past(pend, 2)) |=> !valid);
endmodule

// File: rtl/lsu_align_unit.sv
// Top of the load/store alignment unit. Decodes the operation, forms
// the address, gates memory strobes on alignment and returns formatted
// load data two cycles after the request. Assumes one request per cycle
// and a memory with one-cycle read latency.
module lsu_align_unit
    import lsu_pkg::*;
#(
    parameter int XLEN   = lsu_pkg::XLEN,
    parameter int OFFW   = lsu_pkg::OFFW,
    parameter int LANES  = XLEN / 8,
    parameter int LANE_W = $clog2(XLEN / 8)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [2:0]             req_op,
    input  logic [XLEN-1:0]        base,
    input  logic [OFFW-1:0]        offset,
    input  logic [XLEN-1:0]        st_data,
    output logic [XLEN-LANE_W-1:0] mem_addr,
    output logic                   mem_re,
    output logic [LANES-1:0]       mem_we,
    output logic [XLEN-1:0]        mem_wdata,
    input  logic [XLEN-1:0]        mem_rdata,
    output logic [XLEN-1:0]        ld_result,
    output logic                   ld_valid,
    output logic                   align_fault
);
    lsu_op_e           op;
    logic              is_load, is_store, is_word, is_byte;
    ld_kind_e          kind;
    logic              active, misalign, wr_en;
    logic [LANE_W-1:0] lane;

    // Decode the operation code into access attributes.
    always_comb begin
        op       = lsu_op_e'(req_op);
        is_load  = 1'b0;
        is_store = 1'b0;
        is_word  = 1'b0;
        kind     = LK_WORD;
        case (op)
            OP_LDW:  begin is_load = 1'b1; is_word = 1'b1; end
            OP_LDB:  begin is_load = 1'b1; kind = LK_SBYTE; end
            OP_LDBU: begin is_load = 1'b1; kind = LK_UBYTE; end
            OP_STW:  begin is_store = 1'b1; is_word = 1'b1; end
            OP_STB:  is_store = 1'b1;
            default: ;
        endcase
        is_byte = !is_word;
    end

    lsu_addr_gen #(.XLEN(XLEN), .OFFW(OFFW), .LANE_W(LANE_W)) u_addr (
        .base      (base),
        .offset    (offset),
        .word_acc  (is_word),
        .word_addr (mem_addr),
        .lane      (lane),
        .misalign  (misalign)
    );

    // Gate strobes on request presence and alignment.
    always_comb begin
        active      = req_valid && (is_load || is_store);
        align_fault = active && misalign;
        mem_re      = active && is_load && !misalign;
        wr_en       = active && is_store && !misalign;
    end

    lsu_store_lanes #(.XLEN(XLEN), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .wr_en     (wr_en),
        .byte_mode (is_byte),
        .lane      (lane),
        .src       (st_data),
        .we        (mem_we),
        .wdata     (mem_wdata)
    );

    lsu_load_extend #(.XLEN(XLEN), .LANES(LANES), .LANE_W(LANE_W)) u_load (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (mem_re),
        .kind   (kind),
        .lane   (lane),
        .rdata  (mem_rdata),
        .result (ld_result),
        .valid  (ld_valid)
    );

    assert_fault_blocks_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (mem_we == '0 && !mem_re));
    assert_read_gives_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> ##1 ld_valid);
    assert_byte_store_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd5) |-> ($countones(mem_we) == 1 && !align_fault));
    assert_word_store_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4 && !align_fault) |-> (mem_we == '1));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (mem_we == '0 && !mem_re && !align_fault));
endmodule

// File: tb/lsu_align_unit_tb.sv
// Directed bench for lsu_align_unit with a small word memory model.
module lsu_align_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [31:0] base;
    logic [15:0] offset;
    logic [31:0] st_data;
    logic [29:0] mem_addr;
    logic        mem_re;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic [31:0] ld_result;
    logic        ld_valid;
    logic        align_fault;

    logic [31:0] mem [16];
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_align_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .base(base), .offset(offset), .st_data(st_data), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ld_result(ld_result), .ld_valid(ld_valid),
        .align_fault(align_fault)
    );

    // Memory model: one-cycle read, byte-enabled write.
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr[3:0]];
        for (int i = 0; i < 4; i++)
            if (mem_we[i]) mem[mem_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [31:0] b,
                         input logic [15:0] o, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; base = b; offset = o; st_data = d;
        #1;
    endtask

    task automatic idle_req();
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
    endtask

    // Load scenario: checks request strobes, then result timing and pulse width.
    task automatic t_load(input string tag, input logic [2:0] op, input logic [31:0] b,
                          input logic [15:0] o, input logic [29:0] exp_addr,
                          input logic [31:0] exp_res);
        drive(op, b, o, 32'h0);
        chk({tag, " mem_re"}, {31'b0, mem_re}, 32'd1);
        chk({tag, " mem_addr R1"}, {2'b0, mem_addr}, {2'b0, exp_addr});
        chk({tag, " no write"}, {28'b0, mem_we}, 32'd0);
        idle_req();
        @(negedge clk);
        chk({tag, " ld_valid R2"}, {31'b0, ld_valid}, 32'd1);
        chk({tag, " ld_result"}, ld_result, exp_res);
        @(negedge clk);
        chk({tag, " valid pulse R2"}, {31'b0, ld_valid}, 32'd0);
    endtask

    // Store scenario: checks enables and steered data in the request cycle.
    task automatic t_store(input string tag, input logic [2:0] op, input logic [31:0] b,
                           input logic [15:0] o, input logic [31:0] d,
                           input logic [29:0] exp_addr, input logic [3:0] exp_we,
                           input logic [31:0] exp_wd);
        drive(op, b, o, d);
        chk({tag, " mem_addr R1"}, {2'b0, mem_addr}, {2'b0, exp_addr});
        chk({tag, " mem_we"}, {28'b0, mem_we}, {28'b0, exp_we});
        chk({tag, " mem_wdata"}, mem_wdata, exp_wd);
        chk({tag, " no fault"}, {31'b0, align_fault}, 32'd0);
        idle_req();
    endtask

    // Misaligned scenario: fault, no strobes, no later result.
    task automatic t_misalign(input string tag, input logic [2:0] op, input logic [31:0] b,
                              input logic [15:0] o);
        drive(op, b, o, 32'hFFFF_FFFF);
        chk({tag, " align_fault R3"}, {31'b0, align_fault}, 32'd1);
        chk({tag, " mem_we R3"}, {28'b0, mem_we}, 32'd0);
        chk({tag, " mem_re R3"}, {31'b0, mem_re}, 32'd0);
        idle_req();
        @(negedge clk);
        chk({tag, " no ld_valid R3"}, {31'b0, ld_valid}, 32'd0);
    endtask

    // Quiet scenario: request present but op has no action.
    task automatic t_quiet(input string tag, input logic [2:0] op);
        drive(op, 32'h14, 16'h1, 32'h1234_5678);
        chk({tag, " mem_we R9"}, {28'b0, mem_we}, 32'd0);
        chk({tag, " mem_re R9"}, {31'b0, mem_re}, 32'd0);
        chk({tag, " fault R9"}, {31'b0, align_fault}, 32'd0);
        idle_req();
        @(negedge clk);
        chk({tag, " ld_valid R9"}, {31'b0, ld_valid}, 32'd0);
    endtask

    function automatic logic [31:0] sx8(input logic [7:0] v);
        return {{24{v[7]}}, v};
    endfunction

    function automatic logic [31:0] zx8(input logic [7:0] v);
        return {24'b0, v};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) mem[k] = 32'h1111_1111 * k;
        mem[1] = 32'h0BAD_F00D;
        mem[5] = 32'h80FF_7F01;
        mem[6] = 32'h0;
        mem_rdata = '0;
        rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0;
        base = '0; offset = '0; st_data = '0;
        repeat (4) @(negedge clk);
        // R9: reset state.
        chk("reset ld_valid R9", {31'b0, ld_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("post-reset mem_we R9", {28'b0, mem_we}, 32'd0);
        chk("post-reset mem_re R9", {31'b0, mem_re}, 32'd0);
        chk("post-reset fault R9", {31'b0, align_fault}, 32'd0);

        // R1 R2: word loads with positive, negative and wrapping offsets.
        t_load("LW pos R2", 3'd1, 32'h10, 16'h0004, 30'd5, 32'h80FF_7F01);
        t_load("LW neg R1", 3'd1, 32'h20, 16'hFFF4, 30'd5, 32'h80FF_7F01);
        t_load("LW wrap R1", 3'd1, 32'hFFFF_FFFC, 16'h0008, 30'd1, 32'h0BAD_F00D);

        // R4 R6: signed byte load on every lane.
        for (int k = 0; k < 4; k++)
            t_load($sformatf("LB lane%0d R4 R6", k), 3'd2, 32'h14, 16'(k), 30'd5,
                   sx8(8'(32'h80FF_7F01 >> (8*k))));
        // R5 R6: unsigned byte load on every lane.
        for (int k = 0; k < 4; k++)
            t_load($sformatf("LBU lane%0d R5 R6", k), 3'd3, 32'h14, 16'(k), 30'd5,
                   zx8(8'(32'h80FF_7F01 >> (8*k))));

        // R8: word store then read back.
        t_store("SW R8", 3'd4, 32'h18, 16'h0, 32'hDEAD_BEEF, 30'd6, 4'b1111, 32'hDEAD_BEEF);
        t_load("SW readback R8", 3'd1, 32'h18, 16'h0, 30'd6, 32'hDEAD_BEEF);

        // R7 R6: byte stores on lanes 2 and 3, then read back.
        t_store("SB lane2 R7", 3'd5, 32'h18, 16'h2, 32'h1234_56A5, 30'd6, 4'b0100, 32'hA5A5_A5A5);
        t_store("SB lane3 R7", 3'd5, 32'h1C, 16'hFFFF, 32'hFFFF_FF5A, 30'd6, 4'b1000, 32'h5A5A_5A5A);
        t_load("SB readback R7", 3'd1, 32'h18, 16'h0, 30'd6, 32'h5AA5_BEEF);

        // R3: misaligned word load and store; memory unchanged.
        t_misalign("LW misaligned R3", 3'd1, 32'h14, 16'h1);
        t_misalign("SW misaligned R3", 3'd4, 32'h18, 16'h2);
        t_misalign("SW misaligned3 R3", 3'd4, 32'h1B, 16'h0);
        t_load("misaligned SW left memory R3", 3'd1, 32'h18, 16'h0, 30'd6, 32'h5AA5_BEEF);

        // R9: no-operation and unused codes.
        t_quiet("op none R9", 3'd0);
        t_quiet("op 6 R9", 3'd6);
        t_quiet("op 7 R9", 3'd7);

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule